// File: doc/BRIEF.md
# Character Display Command Decoder

This block sits between a parallel host bus and the internal state of a character display controller. Each host transfer is one strobed cycle that carries two page-select lines, a read/write line and an 8-bit data byte. The block decodes instructions from two instruction pages. It keeps the address counter and records which of three on-chip memories the counter points at: display memory, glyph memory or auxiliary overlay memory. It executes data reads and writes against that memory and steps the counter after each one. It also holds the entry-mode, display-control and function registers, the display shift offset and the overlay line bit.

Every accepted instruction or data transfer starts a busy timer. Clear and home take a long time and all other operations take a short time. Both durations are parameters counted in system clock cycles. While the timer runs, only status reads are served, and each status read returns the busy bit together with the counter value.

Top module: `lcd_instr_unit`

## Requirements
- R1: On the command page (selA=1, selB=0, rdNotWr=0) the highest set bit of dataIn picks the instruction. Bit 7 set: display address load from bits 6..0. Bit 6: glyph address load from bits 5..0. Bit 5: function register = bits 4..0. Bit 4: shift. Bit 3: dispOn/cursorOn/blinkOn = bits 2/1/0. Bit 2: incDir/shiftEn = bits 1/0. Bit 1: home. Only bit 0 set: clear.
- R2: A command-page read (selA=1, selB=0, rdNotWr=1) puts {busy, counter[6:0]} on dataOut one cycle later. It is served even while busy and does not start or extend the busy time.
- R3: A data-page write (selA=1, selB=1) stores the byte in the memory chosen by the last address load, and a data-page read returns that memory's byte on dataOut one cycle later. After either, the counter steps by +1 if incDir=1 and by -1 otherwise.
- R4: The counter wraps modulo 128 for display memory, modulo 64 for glyph memory and modulo 32 for overlay memory.
- R5: On the auxiliary page (selA=0, selB=0, write), 011a_aaaa selects overlay memory at address a, and 0000_001L sets overlayLine to L.
- R6: Clear writes 0x20 to every display memory cell and zero to every overlay cell. It loads counter 0, selects display memory, sets incDir=1 and resets the shift offset to 0.
- R7: Home loads counter 0, selects display memory and resets the shift offset to 0, and leaves display memory contents unchanged.
- R8: Shift with bit 3 = 0 moves the counter by one, and with bit 3 = 1 moves the shift offset (mod 128) by one. Bit 2 = 1 means +1 and 0 means -1. Memory contents are unchanged.
- R9: When shiftEn=1, every data read or write also steps the shift offset in the direction of incDir.
- R10: busy rises on the cycle after an accepted operation. It stays high for LONG_CYC cycles after clear or home and for SHORT_CYC cycles after anything else.
- R11: While busy is high, instruction writes and data-page reads and writes are ignored.
- R12: After reset: busy=0, dataOut=0, counter=0 on display memory, incDir=1, shiftEn=0, display/cursor/blink off, function bits 0, shift offset 0, overlayLine 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | One-cycle host transfer valid |
| selA | input | 1 | Page select, first line |
| selB | input | 1 | Page select, second line |
| rdNotWr | input | 1 | 1 = read, 0 = write |
| dataIn | input | 8 | Host write byte |
| dataOut | output | 8 | Status or memory read byte (registered) |
| busy | output | 1 | Execution in progress |
| dispOn | output | 1 | Display enable |
| cursorOn | output | 1 | Cursor enable |
| blinkOn | output | 1 | Cursor blink enable |
| incDir | output | 1 | Counter direction, 1 = increment |
| shiftEn | output | 1 | Display follows data accesses |
| funcBits | output | 5 | Function register |
| shiftOff | output | 7 | Display shift offset |
| overlayLine | output | 1 | Overlay line select |

## Verification
The hardest case to reach is a transfer that lands inside the busy window. The host side of the bench normally waits for busy to fall, so the tests issue a second strobe on the very next cycle after an accepted instruction. The same back-to-back trick places a status read inside the window. The counter wrap at each memory boundary is reached by loading the last legal address and then writing or reading once in each direction.

// File: rtl/lcd_instr_pkg.sv
package lcd_instr_pkg;
  typedef enum logic [1:0] {TGT_DD, TGT_CG, TGT_AB} tgt_e;

  typedef struct packed {
    logic clear;
    logic home;
    logic entry;
    logic disp;
    logic shift;
    logic func;
    logic setCg;
    logic setDd;
    logic setAb;
    logic setLine;
    logic ramWr;
    logic ramRd;
    logic statRd;
  } strb_t;

  localparam logic [7:0] BLANK_CODE = 8'h20;
endpackage

// File: rtl/lcd_instr_ctrl.sv
module lcd_instr_ctrl
  import lcd_instr_pkg::*;
#(
  parameter int SHORT_CYC = 10,
  parameter int LONG_CYC  = 410
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strobe,
  input  logic       selA,
  input  logic       selB,
  input  logic       rdNotWr,
  input  logic [7:0] dataIn,
  output strb_t      stb,
  output logic       busy
);
  localparam int CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] busyCnt;
  logic isCmd, isData, isAux, startOp, longOp;

  assign isCmd  = selA & ~selB;
  assign isData = selA & selB;
  assign isAux  = ~selA & ~selB;

  always_comb begin
    stb = '0;
    if (strobe) begin
      if (isCmd && rdNotWr) begin
        stb.statRd = 1'b1;
      end else if (!busy) begin
        if (isCmd) begin
          casez (dataIn)
            8'b1???????: stb.setDd = 1'b1;
            8'b01??????: stb.setCg = 1'b1;
            8'b001?????: stb.func  = 1'b1;
            8'b0001????: stb.shift = 1'b1;
            8'b00001???: stb.disp  = 1'b1;
            8'b000001??: stb.entry = 1'b1;
            8'b0000001?: stb.home  = 1'b1;
            8'b00000001: stb.clear = 1'b1;
            default: ;
          endcase
        end else if (isData) begin
          stb.ramRd = rdNotWr;
          stb.ramWr = ~rdNotWr;
        end else if (isAux && !rdNotWr) begin
          if (dataIn[7:5] == 3'b011) stb.setAb = 1'b1;
          else if (dataIn[7:1] == 7'b0000001) stb.setLine = 1'b1;
        end
      end
    end
  end

  assign longOp  = stb.clear | stb.home;
  assign startOp = |{stb.clear, stb.home, stb.entry, stb.disp, stb.shift,
                     stb.func, stb.setCg, stb.setDd, stb.setAb, stb.setLine,
                     stb.ramWr, stb.ramRd};

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else if (startOp) busyCnt <= longOp ? CW'(LONG_CYC) : CW'(SHORT_CYC);
    else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
  end

  assign busy = (busyCnt != '0);
endmodule

// File: rtl/lcd_instr_dp.sv
module lcd_instr_dp
  import lcd_instr_pkg::*;
#(
  parameter int DD_AW = 7,
  parameter int CG_AW = 6,
  parameter int AB_AW = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            stb,
  input  logic             busy,
  input  logic [7:0]       dataIn,
  output logic [7:0]       dataOut,
  output logic             dispOn,
  output logic             cursorOn,
  output logic             blinkOn,
  output logic             incDir,
  output logic             shiftEn,
  output logic [4:0]       funcBits,
  output logic [DD_AW-1:0] shiftOff,
  output logic             overlayLine
);
  localparam int DD_N = 1 << DD_AW;
  localparam int CG_N = 1 << CG_AW;
  localparam int AB_N = 1 << AB_AW;
  localparam logic [DD_AW-1:0] DD_M = DD_AW'(DD_N - 1);
  localparam logic [DD_AW-1:0] CG_M = DD_AW'(CG_N - 1);
  localparam logic [DD_AW-1:0] AB_M = DD_AW'(AB_N - 1);

  logic [7:0] ddMem [DD_N];
  logic [7:0] cgMem [CG_N];
  logic [7:0] abMem [AB_N];

  logic [DD_AW-1:0] acReg, acMask, acStep;
  tgt_e             tgt;
  logic [7:0]       rdByte;
  logic             dataAcc;

  assign dataAcc = stb.ramWr | stb.ramRd;

  always_comb begin
    case (tgt)
      TGT_CG:  acMask = CG_M;
      TGT_AB:  acMask = AB_M;
      default: acMask = DD_M;
    endcase
  end

  assign acStep = (incDir ? acReg + 1'b1 : acReg - 1'b1) & acMask;

  always_comb begin
    case (tgt)
      TGT_CG:  rdByte = cgMem[acReg[CG_AW-1:0]];
      TGT_AB:  rdByte = abMem[acReg[AB_AW-1:0]];
      default: rdByte = ddMem[acReg];
    endcase
  end

  // control registers and counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acReg <= '0; tgt <= TGT_DD; incDir <= 1'b1; shiftEn <= 1'b0;
      dispOn <= 1'b0; cursorOn <= 1'b0; blinkOn <= 1'b0;
      funcBits <= '0; shiftOff <= '0; overlayLine <= 1'b0; dataOut <= '0;
    end else begin
      if (stb.statRd) dataOut <= {busy, 7'(acReg)};
      if (stb.ramRd) dataOut <= rdByte;
      if (stb.clear || stb.home) begin
        acReg <= '0; tgt <= TGT_DD; shiftOff <= '0;
      end
      if (stb.clear) incDir <= 1'b1;
      if (stb.entry) {incDir, shiftEn} <= dataIn[1:0];
      if (stb.disp) {dispOn, cursorOn, blinkOn} <= dataIn[2:0];
      if (stb.func) funcBits <= dataIn[4:0];
      if (stb.setLine) overlayLine <= dataIn[0];
      if (stb.setDd) begin acReg <= dataIn[DD_AW-1:0]; tgt <= TGT_DD; end
      if (stb.setCg) begin acReg <= DD_AW'(dataIn[CG_AW-1:0]); tgt <= TGT_CG; end
      if (stb.setAb) begin acReg <= DD_AW'(dataIn[AB_AW-1:0]); tgt <= TGT_AB; end
      if (stb.shift) begin
        if (dataIn[3]) shiftOff <= dataIn[2] ? shiftOff + 1'b1 : shiftOff - 1'b1;
        else acReg <= (dataIn[2] ? acReg + 1'b1 : acReg - 1'b1) & acMask;
      end
      if (dataAcc) begin
        acReg <= acStep;
        if (shiftEn) shiftOff <= incDir ? shiftOff + 1'b1 : shiftOff - 1'b1;
      end
    end
  end

  // memory arrays
  always_ff @(posedge clk) begin
    if (stb.clear) begin
      for (int i = 0; i < DD_N; i++) ddMem[i] <= BLANK_CODE;
      for (int j = 0; j < AB_N; j++) abMem[j] <= 8'h00;
    end else if (stb.ramWr) begin
      case (tgt)
        TGT_CG:  cgMem[acReg[CG_AW-1:0]] <= dataIn;
        TGT_AB:  abMem[acReg[AB_AW-1:0]] <= dataIn;
        default: ddMem[acReg] <= dataIn;
      endcase
    end
  end
endmodule

// File: rtl/lcd_instr_unit.sv
module lcd_instr_unit
  import lcd_instr_pkg::*;
#(
  parameter int SHORT_CYC = 10,
  parameter int LONG_CYC  = 410
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strobe,
  input  logic       selA,
  input  logic       selB,
  input  logic       rdNotWr,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic       busy,
  output logic       dispOn,
  output logic       cursorOn,
  output logic       blinkOn,
  output logic       incDir,
  output logic       shiftEn,
  output logic [4:0] funcBits,
  output logic [6:0] shiftOff,
  output logic       overlayLine
);
  strb_t stb;

  lcd_instr_ctrl #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selA(selA), .selB(selB),
    .rdNotWr(rdNotWr), .dataIn(dataIn), .stb(stb), .busy(busy)
  );

  lcd_instr_dp #(.DD_AW(7), .CG_AW(6), .AB_AW(5)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .dataIn(dataIn),
    .dataOut(dataOut), .dispOn(dispOn), .cursorOn(cursorOn),
    .blinkOn(blinkOn), .incDir(incDir), .shiftEn(shiftEn),
    .funcBits(funcBits), .shiftOff(shiftOff), .overlayLine(overlayLine)
  );
endmodule

// File: rtl/lcd_instr_chk.sv
module lcd_instr_chk
  import lcd_instr_pkg::*;
#(
  parameter int LONG_CYC = 410
) (
  input logic       clk,
  input logic       rstN,
  input logic       strobe,
  input logic       selA,
  input logic       selB,
  input logic       rdNotWr,
  input logic       busy,
  input logic [7:0] dataOut,
  input logic       dispOn,
  input logic [4:0] funcBits,
  input logic       overlayLine,
  input strb_t      stb
);
  localparam int RW = $clog2(LONG_CYC + 2);
  logic [RW-1:0] busyRun;
  logic statReq, opReq;

  assign statReq = strobe & selA & ~selB & rdNotWr;
  assign opReq = |{stb.clear, stb.home, stb.entry, stb.disp, stb.shift,
                   stb.func, stb.setCg, stb.setDd, stb.setAb, stb.setLine,
                   stb.ramWr, stb.ramRd};

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  assert_busy_after_op_R10: assert property (@(posedge clk) disable iff (!rstN)
    opReq |=> busy);

  assert_busy_bounded_R10: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RW'(LONG_CYC));

  assert_status_no_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (statReq && !busy) |=> !busy);

  assert_status_busy_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    statReq |=> (dataOut[7] == $past(busy)));

  assert_ignore_when_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && strobe && !statReq) |=> ($stable(dispOn) && $stable(funcBits) && $stable(overlayLine)));

  assert_no_op_when_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !opReq);
endmodule

bind lcd_instr_unit lcd_instr_chk #(.LONG_CYC(LONG_CYC)) uChk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .selA(selA), .selB(selB),
  .rdNotWr(rdNotWr), .busy(busy), .dataOut(dataOut), .dispOn(dispOn),
  .funcBits(funcBits), .overlayLine(overlayLine), .stb(stb)
);

// File: tb/sim_lcd_instr_unit.sv
`timescale 1ns/1ps
module sim_lcd_instr_unit;
  localparam int SHORT_CYC = 10;
  localparam int LONG_CYC  = 410;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobe = 1'b0, selA = 1'b0, selB = 1'b0, rdNotWr = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic busy, dispOn, cursorOn, blinkOn, incDir, shiftEn, overlayLine;
  logic [4:0] funcBits;
  logic [6:0] shiftOff;

  int total = 0;
  int bad = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  lcd_instr_unit #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u0 (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selA(selA), .selB(selB),
    .rdNotWr(rdNotWr), .dataIn(dataIn), .dataOut(dataOut), .busy(busy),
    .dispOn(dispOn), .cursorOn(cursorOn), .blinkOn(blinkOn), .incDir(incDir),
    .shiftEn(shiftEn), .funcBits(funcBits), .shiftOff(shiftOff),
    .overlayLine(overlayLine)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic a, input logic b, input logic r, input logic [7:0] d);
    selA = a; selB = b; rdNotWr = r; dataIn = d; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] d);   acc(1, 0, 0, d); waitIdle(); endtask
  task automatic aux(input logic [7:0] d);   acc(0, 0, 0, d); waitIdle(); endtask
  task automatic wr(input logic [7:0] d);    acc(1, 1, 0, d); waitIdle(); endtask
  task automatic rd(output logic [7:0] q);   acc(1, 1, 1, 8'h00); q = dataOut; waitIdle(); endtask
  task automatic stat(output logic [7:0] q); acc(1, 0, 1, 8'h00); q = dataOut; endtask

  task automatic busyLen(input logic [7:0] d, input int exp, input string req);
    int n = 0;
    acc(1, 0, 0, d);
    while (busy) begin n++; @(negedge clk); end
    chk(n == exp, req, n, exp);
  endtask

  task automatic t_reset();
    chk(busy == 0 && dataOut == 8'h00, "R12 busy/dataOut", {busy, dataOut}, 0);
    chk(incDir == 1 && shiftEn == 0, "R12 entry", {incDir, shiftEn}, 2);
    chk({dispOn, cursorOn, blinkOn} == 3'b000, "R12 display", {dispOn, cursorOn, blinkOn}, 0);
    chk(funcBits == 0 && shiftOff == 0 && overlayLine == 0, "R12 func/shift/line",
        {funcBits, shiftOff, overlayLine}, 0);
    stat(v); chk(v == 8'h00, "R12 counter", v, 0);
  endtask

  task automatic t_regs();
    cmd(8'h0D); chk({dispOn, cursorOn, blinkOn} == 3'b101, "R1 display ctrl", {dispOn, cursorOn, blinkOn}, 5);
    cmd(8'h3A); chk(funcBits == 5'h1A, "R1 function", funcBits, 5'h1A);
    cmd(8'h0F); chk({dispOn, cursorOn, blinkOn} == 3'b111, "R1 display ctrl all", {dispOn, cursorOn, blinkOn}, 7);
    cmd(8'h05); chk(incDir == 0 && shiftEn == 1, "R1 entry", {incDir, shiftEn}, 1);
    cmd(8'h06); chk(incDir == 1 && shiftEn == 0, "R1 entry restore", {incDir, shiftEn}, 2);
  endtask

  task automatic t_busy();
    busyLen(8'h80, SHORT_CYC, "R10 short busy");
    busyLen(8'h01, LONG_CYC, "R10 clear long busy");
    busyLen(8'h02, LONG_CYC, "R10 home long busy");
    acc(1, 0, 0, 8'h90);
    stat(v); chk(v == 8'h90, "R2 status while busy", v, 8'h90);
    waitIdle();
    stat(v); chk(v == 8'h10, "R2 status idle", v, 8'h10);
    chk(busy == 0, "R2 status adds no busy", busy, 0);
  endtask

  task automatic t_data();
    cmd(8'h90); wr(8'hA1); wr(8'hB2);
    stat(v); chk(v == 8'h12, "R3 counter after writes", v, 8'h12);
    cmd(8'h90);
    rd(v); chk(v == 8'hA1, "R3 read first", v, 8'hA1);
    rd(v); chk(v == 8'hB2, "R3 read second", v, 8'hB2);
    stat(v); chk(v == 8'h12, "R3 counter after reads", v, 8'h12);
  endtask

  task automatic t_wrap();
    cmd(8'h04); cmd(8'h80); wr(8'h11);
    stat(v); chk(v == 8'h7F, "R4 display wrap down", v, 8'h7F);
    cmd(8'h06); cmd(8'hFF); wr(8'h22);
    stat(v); chk(v == 8'h00, "R4 display wrap up", v, 0);
    cmd(8'h7F); wr(8'h55);
    stat(v); chk(v == 8'h00, "R4 glyph wrap", v, 0);
    cmd(8'h7F); rd(v); chk(v == 8'h55, "R4 glyph readback", v, 8'h55);
    aux(8'h7F); wr(8'h66);
    stat(v); chk(v == 8'h00, "R4 overlay wrap", v, 0);
    aux(8'h7F); rd(v); chk(v == 8'h66, "R4 overlay readback", v, 8'h66);
  endtask

  task automatic t_aux();
    aux(8'h63); wr(8'h9C);
    stat(v); chk(v == 8'h04, "R5 overlay address", v, 4);
    aux(8'h63); rd(v); chk(v == 8'h9C, "R5 overlay data", v, 8'h9C);
    aux(8'h03); chk(overlayLine == 1, "R5 line set", overlayLine, 1);
    aux(8'h02); chk(overlayLine == 0, "R5 line clear", overlayLine, 0);
  endtask

  task automatic t_shift();
    cmd(8'h85);
    cmd(8'h14); stat(v); chk(v == 8'h06, "R8 cursor right", v, 6);
    cmd(8'h10); stat(v); chk(v == 8'h05, "R8 cursor left", v, 5);
    cmd(8'h1C); chk(shiftOff == 7'h01, "R8 display right", shiftOff, 1);
    cmd(8'h18); cmd(8'h18); chk(shiftOff == 7'h7F, "R8 display left wrap", shiftOff, 7'h7F);
    cmd(8'h1C);
    stat(v); chk(v == 8'h05, "R8 display shift keeps counter", v, 5);
    cmd(8'h90); rd(v); chk(v == 8'hA1, "R8 memory unchanged", v, 8'hA1);
  endtask

  task automatic t_entryShift();
    cmd(8'h07); cmd(8'h80); wr(8'h33);
    chk(shiftOff == 7'h01, "R9 shift on write", shiftOff, 1);
    cmd(8'h80); rd(v);
    chk(shiftOff == 7'h02, "R9 shift on read", shiftOff, 2);
    cmd(8'h06);
  endtask

  task automatic t_home();
    cmd(8'h02);
    stat(v); chk(v == 8'h00, "R7 counter zero", v, 0);
    chk(shiftOff == 0, "R7 shift reset", shiftOff, 0);
    cmd(8'h90); rd(v); chk(v == 8'hA1, "R7 memory kept", v, 8'hA1);
  endtask

  task automatic t_ignore();
    acc(1, 0, 0, 8'h08);
    acc(1, 0, 0, 8'h0F);
    waitIdle();
    chk(dispOn == 0, "R11 instruction ignored", dispOn, 0);
    cmd(8'h85); wr(8'h44);
    acc(1, 0, 0, 8'h85);
    acc(1, 1, 0, 8'h77);
    waitIdle();
    stat(v); chk(v == 8'h05, "R11 write ignored counter", v, 5);
    rd(v); chk(v == 8'h44, "R11 write ignored data", v, 8'h44);
  endtask

  task automatic t_clear();
    cmd(8'h1C); cmd(8'h04);
    aux(8'h60); wr(8'h5A);
    cmd(8'h01);
    stat(v); chk(v == 8'h00, "R6 counter zero", v, 0);
    chk(incDir == 1 && shiftOff == 0, "R6 entry/shift", {incDir, shiftOff}, 8'h80);
    cmd(8'h90); rd(v); chk(v == 8'h20, "R6 blank 0x10", v, 8'h20);
    cmd(8'h85); rd(v); chk(v == 8'h20, "R6 blank 0x05", v, 8'h20);
    aux(8'h60); rd(v); chk(v == 8'h00, "R6 overlay cleared", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_busy();
    t_data();
    t_wrap();
    t_aux();
    t_shift();
    t_entryShift();
    t_home();
    t_ignore();
    t_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule